// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Bridge

This block sits between a processor whose low address byte shares pins with its 8-bit data bus and the memory and I/O devices of a small system. On each clock edge where the address strobe is high, it captures the low byte from the shared pins and the upper address lines. It holds that address until the next strobe. The memories receive a 15-bit address, and one further latched bit picks the region.

The data path is steered by an active-low data enable and a direction signal. The shared bus is modelled as separate input, output and output-enable ports on each side, so at most one side is driven at a time. The memory/IO select and the active-low read and write strobes are combined into four active-low command strobes. The region bit produces active-low chip selects: a lower RAM half at 0x0000–0x7FFF and an upper ROM half at 0x8000–0xFFFF.

Top module: `bus_bridge`

## Requirements
- R1: While `rst_ni` is low, and at the first clock edge after its release, `mem_addr_o` is 0. All four command strobes and both chip selects read 1, and both output enables read 0, whatever the other inputs are.
- R2: On a rising clock edge where `ale_i` is 1, the address {`a_hi_i`,`ad_i`} is captured. From that edge onward, `mem_addr_o` equals bits 14..0 of that address.
- R3: On edges where `ale_i` is 0, the captured address is kept unchanged, whatever happens on `ad_i` and `a_hi_i`.
- R4: While `den_ni` is 1, both `sys_oe_o` and `cpu_oe_o` are 0, and `sys_data_o` and `cpu_data_o` are 0.
- R5: While `den_ni` is 0 and `dtr_i` is 1 (write direction), `sys_oe_o` is 1, `sys_data_o` equals `ad_i`, and `cpu_oe_o` is 0.
- R6: While `den_ni` is 0 and `dtr_i` is 0 (read direction), `cpu_oe_o` is 1, `cpu_data_o` equals `sys_data_i`, and `sys_oe_o` is 0.
- R7: With `io_m_i` = 0 (memory cycle): `rd_ni` = 0 with `wr_ni` = 1 drives `mem_rd_no` low, and `wr_ni` = 0 with `rd_ni` = 1 drives `mem_wr_no` low. Both I/O strobes stay high.
- R8: With `io_m_i` = 1 (I/O cycle): `rd_ni` = 0 with `wr_ni` = 1 drives `io_rd_no` low, and `wr_ni` = 0 with `rd_ni` = 1 drives `io_wr_no` low. Both memory strobes stay high.
- R9: When `rd_ni` and `wr_ni` are both 0, or both 1, all four command strobes are 1. At most one strobe is ever low.
- R10: A captured address bit 15 of 0 gives `ram_cs_no` = 0 and `rom_cs_no` = 1. A value of 1 gives `rom_cs_no` = 0 and `ram_cs_no` = 1.
- R11: `ram_cs_no` and `rom_cs_no` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address strobe, capture when high |
| ad_i | input | 8 | Shared pins, processor side: low address byte or write data |
| a_hi_i | input | 8 | Address lines 15..8 |
| io_m_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| den_ni | input | 1 | Data enable, active low |
| dtr_i | input | 1 | Direction: 1 = toward system, 0 = toward processor |
| sys_data_i | input | 8 | System-side data in |
| sys_data_o | output | 8 | System-side data out |
| sys_oe_o | output | 1 | System-side drive enable |
| cpu_data_o | output | 8 | Processor-side data out |
| cpu_oe_o | output | 1 | Processor-side drive enable |
| mem_addr_o | output | 15 | Held address to the memories |
| mem_rd_no | output | 1 | Memory read command, active low |
| mem_wr_no | output | 1 | Memory write command, active low |
| io_rd_no | output | 1 | I/O read command, active low |
| io_wr_no | output | 1 | I/O write command, active low |
| ram_cs_no | output | 1 | Lower-half select, active low |
| rom_cs_no | output | 1 | Upper-half select, active low |

## Verification
The properties assume that the inputs are set up between clock edges. Under that assumption, a value present on `ad_i` and `a_hi_i` at a strobe edge is the one that must appear on `mem_addr_o` afterwards. The bench respects this by changing every input on the falling edge only. The command and direction inputs are treated as free: the bench also drives the combinations a real processor never produces, such as simultaneous read and write, and data enable without a strobe. The properties that claim at most one strobe and at most one driver must hold for those combinations too.

// File: rtl/bus_bridge_pkg.sv
package bus_bridge_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_BIT = 15;
  localparam int unsigned LATCH_W = SEL_BIT + 1;
  localparam int unsigned HI_W = LATCH_W - DATA_W;
  localparam int unsigned MEM_AW = SEL_BIT;
  localparam int unsigned NUM_CMD = 4;

  // index into the command vector: bit1 = io space, bit0 = write
  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'd0,
    CMD_MEM_WR = 2'd1,
    CMD_IO_RD  = 2'd2,
    CMD_IO_WR  = 2'd3
  } cmd_e;
endpackage

// File: rtl/bus_bridge_addr_latch.sv
module bus_bridge_addr_latch #(
  parameter int unsigned LW = bus_bridge_pkg::LATCH_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic [LW-1:0] addr_i,
  output logic [LW-1:0] addr_o,
  output logic          live_o
);
  logic [LW-1:0] addr_q;
  logic          live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (ale_i) begin
      addr_q <= addr_i;
    end
  end

  // strobes unlock one edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assign addr_o = addr_q;
  assign live_o = live_q;
endmodule

// File: rtl/bus_bridge_data_steer.sv
module bus_bridge_data_steer #(
  parameter int unsigned DW = bus_bridge_pkg::DATA_W
) (
  input  logic          live_i,
  input  logic          den_ni,
  input  logic          dtr_i,
  input  logic [DW-1:0] cpu_data_i,
  input  logic [DW-1:0] sys_data_i,
  output logic [DW-1:0] sys_data_o,
  output logic          sys_oe_o,
  output logic [DW-1:0] cpu_data_o,
  output logic          cpu_oe_o
);
  logic en;

  assign en = live_i & ~den_ni;

  always_comb begin
    sys_oe_o   = en & dtr_i;
    cpu_oe_o   = en & ~dtr_i;
    sys_data_o = sys_oe_o ? cpu_data_i : '0;
    cpu_data_o = cpu_oe_o ? sys_data_i : '0;
  end
endmodule

// File: rtl/bus_bridge_cmd_decode.sv
module bus_bridge_cmd_decode #(
  parameter int unsigned NC = bus_bridge_pkg::NUM_CMD
) (
  input  logic          live_i,
  input  logic          io_m_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  output logic [NC-1:0] cmd_no
);
  logic rd_only;
  logic wr_only;

  // simultaneous read and write yields no command
  assign rd_only = ~rd_ni & wr_ni;
  assign wr_only = ~wr_ni & rd_ni;

  for (genvar k = 0; k < NC; k++) begin : g_cmd
    localparam logic [1:0] CODE  = 2'(k);
    localparam logic       IS_IO = CODE[1];
    localparam logic       IS_WR = CODE[0];
    logic hit;
    assign hit       = live_i & (io_m_i == IS_IO) & (IS_WR ? wr_only : rd_only);
    assign cmd_no[k] = ~hit;
  end
endmodule

// File: rtl/bus_bridge_region_sel.sv
module bus_bridge_region_sel (
  input  logic live_i,
  input  logic sel_i,
  output logic ram_cs_no,
  output logic rom_cs_no
);
  assign ram_cs_no = ~(live_i & ~sel_i);
  assign rom_cs_no = ~(live_i & sel_i);
endmodule

// File: rtl/bus_bridge.sv
module bus_bridge
  import bus_bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [HI_W-1:0]   a_hi_i,
  input  logic              io_m_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              den_ni,
  input  logic              dtr_i,
  input  logic [DATA_W-1:0] sys_data_i,
  output logic [DATA_W-1:0] sys_data_o,
  output logic              sys_oe_o,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              cpu_oe_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              ram_cs_no,
  output logic              rom_cs_no
);
  logic [LATCH_W-1:0] addr_q;
  logic               live;
  logic [NUM_CMD-1:0] cmd_n;

  bus_bridge_addr_latch #(.LW(LATCH_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .addr_i ({a_hi_i, ad_i}),
    .addr_o (addr_q),
    .live_o (live)
  );

  bus_bridge_data_steer #(.DW(DATA_W)) u_steer (
    .live_i     (live),
    .den_ni     (den_ni),
    .dtr_i      (dtr_i),
    .cpu_data_i (ad_i),
    .sys_data_i (sys_data_i),
    .sys_data_o (sys_data_o),
    .sys_oe_o   (sys_oe_o),
    .cpu_data_o (cpu_data_o),
    .cpu_oe_o   (cpu_oe_o)
  );

  bus_bridge_cmd_decode #(.NC(NUM_CMD)) u_cmd (
    .live_i (live),
    .io_m_i (io_m_i),
    .rd_ni  (rd_ni),
    .wr_ni  (wr_ni),
    .cmd_no (cmd_n)
  );

  bus_bridge_region_sel u_region (
    .live_i    (live),
    .sel_i     (addr_q[SEL_BIT]),
    .ram_cs_no (ram_cs_no),
    .rom_cs_no (rom_cs_no)
  );

  assign mem_addr_o = addr_q[MEM_AW-1:0];
  assign mem_rd_no  = cmd_n[CMD_MEM_RD];
  assign mem_wr_no  = cmd_n[CMD_MEM_WR];
  assign io_rd_no   = cmd_n[CMD_IO_RD];
  assign io_wr_no   = cmd_n[CMD_IO_WR];
endmodule

// File: rtl/bus_bridge_chk.sv
module bus_bridge_chk
  import bus_bridge_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_i,
  input logic [DATA_W-1:0] ad_i,
  input logic [HI_W-1:0]   a_hi_i,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic              den_ni,
  input logic              sys_oe_o,
  input logic              cpu_oe_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              mem_rd_no,
  input logic              mem_wr_no,
  input logic              io_rd_no,
  input logic              io_wr_no,
  input logic              ram_cs_no,
  input logic              rom_cs_no,
  input logic              sel_q
);
  logic [LATCH_W-1:0] bus_addr;
  logic [3:0]         strobes_n;

  assign bus_addr  = {a_hi_i, ad_i};
  assign strobes_n = {io_wr_no, io_rd_no, mem_wr_no, mem_rd_no};

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |=> mem_addr_o == $past(bus_addr[MEM_AW-1:0]));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(mem_addr_o));

  assert_idle_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    den_ni |-> (!sys_oe_o && !cpu_oe_o));

  assert_one_driver_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_oe_o && cpu_oe_o));

  assert_no_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni == wr_ni) |-> (strobes_n == 4'hF));

  assert_single_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~strobes_n) <= 1);

  assert_ram_region_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_cs_no |-> !sel_q);

  assert_rom_region_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_cs_no |-> sel_q);

  assert_cs_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_cs_no && !rom_cs_no));
endmodule

bind bus_bridge bus_bridge_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ale_i      (ale_i),
  .ad_i       (ad_i),
  .a_hi_i     (a_hi_i),
  .rd_ni      (rd_ni),
  .wr_ni      (wr_ni),
  .den_ni     (den_ni),
  .sys_oe_o   (sys_oe_o),
  .cpu_oe_o   (cpu_oe_o),
  .mem_addr_o (mem_addr_o),
  .mem_rd_no  (mem_rd_no),
  .mem_wr_no  (mem_wr_no),
  .io_rd_no   (io_rd_no),
  .io_wr_no   (io_wr_no),
  .ram_cs_no  (ram_cs_no),
  .rom_cs_no  (rom_cs_no),
  .sel_q      (addr_q[bus_bridge_pkg::SEL_BIT])
);

// File: tb/bus_bridge_bench.sv
`timescale 1ns/1ps
module bus_bridge_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic [7:0] ad = 8'h00;
  logic [7:0] a_hi = 8'h00;
  logic       io_m = 1'b0;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       den_n = 1'b1;
  logic       dtr = 1'b0;
  logic [7:0] sys_in = 8'h00;
  logic [7:0] sys_out;
  logic       sys_oe;
  logic [7:0] cpu_out;
  logic       cpu_oe;
  logic [14:0] maddr;
  logic       mrd_n, mwr_n, iord_n, iowr_n, ram_n, rom_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_bridge u_bus_bridge (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .ad_i(ad), .a_hi_i(a_hi),
    .io_m_i(io_m), .rd_ni(rd_n), .wr_ni(wr_n), .den_ni(den_n), .dtr_i(dtr),
    .sys_data_i(sys_in), .sys_data_o(sys_out), .sys_oe_o(sys_oe),
    .cpu_data_o(cpu_out), .cpu_oe_o(cpu_oe), .mem_addr_o(maddr),
    .mem_rd_no(mrd_n), .mem_wr_no(mwr_n), .io_rd_no(iord_n), .io_wr_no(iowr_n),
    .ram_cs_no(ram_n), .rom_cs_no(rom_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // fields: io_m rd_n wr_n den_n dtr | strobes {iowr,iord,mwr,mrd} | sys_oe cpu_oe
  localparam logic [10:0] VEC [0:9] = '{
    {5'b0_0_1_0_0, 4'b1110, 2'b01},  // R7 mem read
    {5'b0_1_0_0_1, 4'b1101, 2'b10},  // R7 mem write
    {5'b1_0_1_0_0, 4'b1011, 2'b01},  // R8 io read
    {5'b1_1_0_0_1, 4'b0111, 2'b10},  // R8 io write
    {5'b0_0_0_0_0, 4'b1111, 2'b01},  // R9 both low
    {5'b1_0_0_1_1, 4'b1111, 2'b00},  // R9 both low, R4
    {5'b0_1_1_1_0, 4'b1111, 2'b00},  // R9 none, R4
    {5'b1_1_1_0_1, 4'b1111, 2'b10},  // R9 none, R5
    {5'b0_0_1_1_0, 4'b1110, 2'b00},  // R7, R4
    {5'b1_1_0_1_1, 4'b0111, 2'b00}   // R8, R4
  };

  task automatic latch(input logic [15:0] a);
    @(negedge clk);
    ale = 1'b1; ad = a[7:0]; a_hi = a[15:8];
    @(negedge clk);
    ale = 1'b0; ad = ~a[7:0]; a_hi = ~a[15:8];
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // R1 during reset with active-looking inputs
    io_m = 1'b0; rd_n = 1'b0; den_n = 1'b0; dtr = 1'b1; ale = 1'b1; ad = 8'hFF; a_hi = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 addr", 32'(maddr), 32'h0);
    chk("R1 strobes", 32'({iowr_n, iord_n, mwr_n, mrd_n}), 32'hF);
    chk("R1 cs", 32'({ram_n, rom_n}), 32'h3);
    chk("R1 oe", 32'({sys_oe, cpu_oe}), 32'h0);
    ale = 1'b0; rd_n = 1'b1; den_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 addr after release", 32'(maddr), 32'h0);
    chk("R10 ram after reset", 32'({ram_n, rom_n}), 32'h1);

    ad = 8'hA5; sys_in = 8'h3C;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      {io_m, rd_n, wr_n, den_n, dtr} = VEC[i][10:6];
      #1;
      chk("R7/R8/R9 strobes", 32'({iowr_n, iord_n, mwr_n, mrd_n}), 32'(VEC[i][5:2]));
      chk("R4/R5/R6 oe", 32'({sys_oe, cpu_oe}), 32'(VEC[i][1:0]));
      chk("R5 sys data", 32'(sys_out), VEC[i][1] ? 32'hA5 : 32'h0);
      chk("R6 cpu data", 32'(cpu_out), VEC[i][0] ? 32'h3C : 32'h0);
    end
    rd_n = 1'b1; wr_n = 1'b1; den_n = 1'b1;

    // R2 capture, R10 upper half
    latch(16'h9234);
    chk("R2 capture", 32'(maddr), 32'h1234);
    chk("R10 rom sel", 32'({ram_n, rom_n}), 32'h2);
    // R3 hold with bus activity
    repeat (3) begin
      @(negedge clk);
      ad = ad + 8'h11; a_hi = a_hi ^ 8'hC3;
    end
    #1;
    chk("R3 hold", 32'(maddr), 32'h1234);
    chk("R11 cs excl", 32'(ram_n | rom_n), 32'h1);

    latch(16'h7FFF);
    chk("R2 boundary low", 32'(maddr), 32'h7FFF);
    chk("R10 ram top", 32'({ram_n, rom_n}), 32'h1);
    latch(16'h8000);
    chk("R2 boundary high", 32'(maddr), 32'h0000);
    chk("R10 rom bottom", 32'({ram_n, rom_n}), 32'h2);
    latch(16'h0ABC);
    chk("R2 low region", 32'(maddr), 32'h0ABC);
    chk("R10 ram sel", 32'({ram_n, rom_n}), 32'h1);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0; rd_n = 1'b0; den_n = 1'b0;
    #1;
    chk("R1 async addr", 32'(maddr), 32'h0);
    chk("R1 async strobes", 32'({iowr_n, iord_n, mwr_n, mrd_n}), 32'hF);
    chk("R1 async oe", 32'({sys_oe, cpu_oe}), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule